// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is a fully associative translation buffer whose contents are loaded and inspected by software. Every entry maps an aligned pair of neighbouring virtual pages, an even one and an odd one, onto two independent physical frames. The pair's size is set per entry by a page-size mask. Entries are tagged with an 8-bit address-space identifier, or marked global so that they match in every address space.

The surrounding control-register file supplies the current page-mask, entry-high, two entry-low and index words on ports. The block carries out one operation per accepted request. A probe searches for the entry that matches the current entry-high word. An indexed read copies one entry back out. A write loads an entry at the given index or at a slot given by a random-slot input. Next to these requests, a purely combinational lookup port translates a virtual address using the address-space identifier of the current entry-high word. It returns the physical address and the dirty, valid and global flags.

Top module: `tlb_core`

## Requirements
- R1: After reset both result strobes (`res_idx_vld`, `rd_vld`) are low and every entry reads back as all zeros.
- R2: A probe (op_code 0) raises `res_idx_vld` for one cycle on the next clock with `res_idx` = 0x80000000 on a miss, or the matching entry number with bit 31 clear on a hit. An entry matches when the virtual page-pair number (bits 31:13) of `ehi_in` and of the entry agree under the mask ~(entry page-mask + 0x1FFF), and the entry is either global or its identifier (bits 7:0) equals that of `ehi_in`.
- R3: When several entries match, the lowest-numbered one is reported by both the probe and the lookup.
- R4: A write (op_code 2 or 3) stores the entry-high word with bit 12 (global) set only if bit 0 (global) is set in both entry-low words, and stores both entry-low words with bit 0 cleared.
- R5: An indexed read (op_code 1) raises `rd_vld` for one cycle on the next clock and returns the entry's page-mask and entry words. If the stored global bit is set, bit 0 is set in both returned entry-low words. Bit 12 of the returned entry-high word is always 0.
- R6: op_code 3 writes to the slot given by `rnd_in`. op_code 2 writes to `index_in`, or to `rnd_in` when bit 31 of `index_in` is set.
- R7: A read or write whose slot number, taken as a 32-bit value, is not below the entry count has no effect: no strobe and no entry changed.
- R8: For a hit, the page size is (page-mask + 0x2000) >> 1. The lookup uses the even-page entry-low word when the virtual-address bit at that size is 0, and the odd-page word when it is 1.
- R9: The physical address is the frame number (entry-low bits 29:6) shifted left by 12, plus the virtual address modulo the page size, truncated to PA_W bits.
- R10: The lookup returns `lk_hit`, the entry number, the dirty (entry-low bit 2) and valid (bit 1) flags of the chosen half and the stored global bit. On a miss every lookup output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, one operation per cycle |
| op_code | input | 2 | 0 probe, 1 read, 2 indexed write, 3 random write |
| pmask_in | input | 32 | Current page-mask word |
| ehi_in | input | 32 | Current entry-high word (page-pair number, identifier) |
| elo0_in | input | 32 | Current even-page entry-low word |
| elo1_in | input | 32 | Current odd-page entry-low word |
| index_in | input | 32 | Current index word, bit 31 is the probe-failed flag |
| rnd_in | input | 32 | Random slot number |
| res_idx_vld | output | 1 | Probe result strobe |
| res_idx | output | 32 | Probe result index word |
| rd_vld | output | 1 | Read result strobe |
| rd_pmask | output | 32 | Read page-mask word |
| rd_ehi | output | 32 | Read entry-high word |
| rd_elo0 | output | 32 | Read even-page entry-low word |
| rd_elo1 | output | 32 | Read odd-page entry-low word |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_index | output | IDX_W | Entry number of the hit |
| lk_pa | output | PA_W | Physical address |
| lk_dirty | output | 1 | Dirty flag of the chosen half |
| lk_valid | output | 1 | Valid flag of the chosen half |
| lk_global | output | 1 | Global flag of the hit entry |

## Verification
The bench builds the block with ENTRIES = 4 and PA_W = 28. With four entries, slot numbers 4 to 7 fit in the same index field and the random-slot input, so the ignored out-of-range reads and writes are reachable without large indices. The 28-bit physical bus sits below the widest frame-number product, so the truncation of the physical address shows up at the port. A 64 KiB page-mask entry moves the even/odd selector off bit 12, and a duplicated tag exercises lowest-entry priority for both the probe and the lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] hi;
        logic [31:0] lo0;
        logic [31:0] lo1;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        OP_PROBE  = 2'd0,
        OP_READ   = 2'd1,
        OP_WR_IDX = 2'd2,
        OP_WR_RND = 2'd3
    } tlb_op_e;

    localparam logic [31:0] VPN2_MASK  = 32'hFFFF_E000;
    localparam logic [31:0] PROBE_MISS = 32'h8000_0000;
    localparam int          HI_G_BIT   = 12;
    localparam int          LO_G_BIT   = 0;
    localparam int          LO_V_BIT   = 1;
    localparam int          LO_D_BIT   = 2;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_slot,
    input  tlb_ent_t                    wr_ent,
    output tlb_ent_t [ENTRIES-1:0]      ents
);

    tlb_ent_t [ENTRIES-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (wr_en) begin
            ents_d[wr_slot] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents = ents_q;

    // R4
    stored_lo_g_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ents_q[$past(wr_slot)].lo0[LO_G_BIT] == 1'b0) &&
                  (ents_q[$past(wr_slot)].lo1[LO_G_BIT] == 1'b0));

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [31:0]            vpn,
    input  logic [7:0]             asid,
    output logic [ENTRIES-1:0]     hit_vec
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [31:0] cmp_mask;
        logic        tag_eq;
        logic        id_ok;
        assign cmp_mask = ~(ents[g].mask + 32'h0000_1FFF);
        assign tag_eq   = ((vpn & VPN2_MASK & cmp_mask) ==
                           (ents[g].hi & VPN2_MASK & cmp_mask));
        assign id_ok    = ents[g].hi[HI_G_BIT] || (ents[g].hi[7:0] == asid);
        assign hit_vec[g] = tag_eq && id_ok;
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hit_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PA_W    = 32,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic [31:0]        pmask_in,
    input  logic [31:0]        ehi_in,
    input  logic [31:0]        elo0_in,
    input  logic [31:0]        elo1_in,
    input  logic [31:0]        index_in,
    input  logic [31:0]        rnd_in,
    output logic               res_idx_vld,
    output logic [31:0]        res_idx,
    output logic               rd_vld,
    output logic [31:0]        rd_pmask,
    output logic [31:0]        rd_ehi,
    output logic [31:0]        rd_elo0,
    output logic [31:0]        rd_elo1,
    input  logic [31:0]        lk_va,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_index,
    output logic [PA_W-1:0]    lk_pa,
    output logic               lk_dirty,
    output logic               lk_valid,
    output logic               lk_global
);

    localparam logic [31:0] NENT = 32'(ENTRIES);

    typedef struct packed {
        logic        idx_vld;
        logic [31:0] idx_val;
        logic        rd_vld;
        tlb_ent_t    rd_ent;
    } res_t;

    res_t res_d, res_q;

    tlb_ent_t [ENTRIES-1:0] ents;
    logic                   wr_en;
    logic [IDX_W-1:0]       wr_slot;
    tlb_ent_t               wr_ent;
    logic [31:0]            wslot;
    tlb_ent_t               rd_src;
    tlb_op_e                op;

    logic [ENTRIES-1:0]     pr_hv, lk_hv;
    logic                   pr_any, lk_any;
    logic [IDX_W-1:0]       pr_idx, lk_idx;

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_ent(wr_ent), .ents(ents)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_pr_match (
        .ents(ents), .vpn(ehi_in), .asid(ehi_in[7:0]), .hit_vec(pr_hv)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents(ents), .vpn(lk_va), .asid(ehi_in[7:0]), .hit_vec(lk_hv)
    );

    tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pr_pick (
        .hit_vec(pr_hv), .any(pr_any), .idx(pr_idx)
    );

    tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
        .hit_vec(lk_hv), .any(lk_any), .idx(lk_idx)
    );

    // Request path: probe, read, write
    always_comb begin
        op          = tlb_op_e'(op_code);
        res_d       = res_q;
        res_d.idx_vld = 1'b0;
        res_d.rd_vld  = 1'b0;
        wr_en       = 1'b0;
        wr_slot     = '0;
        wr_ent      = '0;
        rd_src      = ents[index_in[IDX_W-1:0]];
        wslot       = ((op == OP_WR_RND) || index_in[31]) ? rnd_in : index_in;
        if (op_valid) begin
            case (op)
                OP_PROBE: begin
                    res_d.idx_vld = 1'b1;
                    res_d.idx_val = pr_any ? 32'(pr_idx) : PROBE_MISS;
                end
                OP_READ: begin
                    if (index_in < NENT) begin
                        res_d.rd_vld = 1'b1;
                        res_d.rd_ent = rd_src;
                        res_d.rd_ent.hi[HI_G_BIT] = 1'b0;
                        if (rd_src.hi[HI_G_BIT]) begin
                            res_d.rd_ent.lo0[LO_G_BIT] = 1'b1;
                            res_d.rd_ent.lo1[LO_G_BIT] = 1'b1;
                        end
                    end
                end
                default: begin
                    if (wslot < NENT) begin
                        wr_en   = 1'b1;
                        wr_slot = wslot[IDX_W-1:0];
                        wr_ent.mask = pmask_in;
                        wr_ent.hi   = ehi_in;
                        wr_ent.hi[HI_G_BIT] = elo0_in[LO_G_BIT] & elo1_in[LO_G_BIT];
                        wr_ent.lo0  = elo0_in;
                        wr_ent.lo1  = elo1_in;
                        wr_ent.lo0[LO_G_BIT] = 1'b0;
                        wr_ent.lo1[LO_G_BIT] = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_idx_vld = res_q.idx_vld;
    assign res_idx     = res_q.idx_val;
    assign rd_vld      = res_q.rd_vld;
    assign rd_pmask    = res_q.rd_ent.mask;
    assign rd_ehi      = res_q.rd_ent.hi;
    assign rd_elo0     = res_q.rd_ent.lo0;
    assign rd_elo1     = res_q.rd_ent.lo1;

    // Lookup path, combinational
    tlb_ent_t    lk_ent;
    logic [31:0] lk_psize;
    logic [31:0] lk_lo;
    logic        lk_odd;

    always_comb begin
        lk_ent   = ents[lk_idx];
        lk_psize = (lk_ent.mask + 32'h0000_2000) >> 1;
        lk_odd   = |(lk_va & lk_psize);
        lk_lo    = lk_odd ? lk_ent.lo1 : lk_ent.lo0;
        lk_hit    = lk_any;
        lk_index  = lk_any ? lk_idx : '0;
        lk_pa     = lk_any ? PA_W'({4'b0000, lk_lo[29:6], 12'h000} +
                                   {4'b0000, lk_va & (lk_psize - 32'd1)}) : '0;
        lk_dirty  = lk_any & lk_lo[LO_D_BIT];
        lk_valid  = lk_any & lk_lo[LO_V_BIT];
        lk_global = lk_any & lk_ent.hi[HI_G_BIT];
    end

    // R2
    probe_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd0 && !pr_any) |=> (res_idx_vld && res_idx == PROBE_MISS));

    // R2
    probe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd0 && pr_any) |=> (res_idx_vld && !res_idx[31]));

    // R5
    read_g_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (!rd_ehi[HI_G_BIT] && (rd_elo0[LO_G_BIT] == rd_elo1[LO_G_BIT])));

    // R7
    read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd1 && index_in >= NENT) |=> !rd_vld);

    // R3
    lookup_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_hv[lk_index]);

    // R10
    lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_dirty && !lk_valid && !lk_global && lk_pa == '0));

endmodule

// File: tb/sim_tlb_core.sv
`timescale 1ns/1ps
module sim_tlb_core;

    localparam int N  = 4;
    localparam int PW = 28;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = '0;
    logic [31:0]   pmask_in = '0, ehi_in = '0, elo0_in = '0, elo1_in = '0;
    logic [31:0]   index_in = '0, rnd_in = '0, lk_va = '0;
    logic          res_idx_vld, rd_vld;
    logic [31:0]   res_idx, rd_pmask, rd_ehi, rd_elo0, rd_elo1;
    logic          lk_hit, lk_dirty, lk_valid, lk_global;
    logic [IW-1:0] lk_index;
    logic [PW-1:0] lk_pa;

    always #10 clk = ~clk;

    tlb_core #(.ENTRIES(N), .PA_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .pmask_in(pmask_in), .ehi_in(ehi_in), .elo0_in(elo0_in), .elo1_in(elo1_in),
        .index_in(index_in), .rnd_in(rnd_in),
        .res_idx_vld(res_idx_vld), .res_idx(res_idx), .rd_vld(rd_vld),
        .rd_pmask(rd_pmask), .rd_ehi(rd_ehi), .rd_elo0(rd_elo0), .rd_elo1(rd_elo1),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_index(lk_index), .lk_pa(lk_pa),
        .lk_dirty(lk_dirty), .lk_valid(lk_valid), .lk_global(lk_global)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the stored entries
    logic [31:0] m_mask [N];
    logic [31:0] m_hi   [N];
    logic [31:0] m_lo0  [N];
    logic [31:0] m_lo1  [N];

    typedef struct {
        bit          is_read;
        logic [31:0] w0, w1, w2, w3;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected results as the strobes appear
    initial begin
        forever begin
            @(negedge clk);
            if (rd_vld || res_idx_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected result strobe",
                          {126'd0, rd_vld, res_idx_vld}, 128'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_read) begin
                        check(rd_vld && (rd_pmask == e.w0) && (rd_ehi == e.w1) &&
                              (rd_elo0 == e.w2) && (rd_elo1 == e.w3), e.req, "read",
                              {rd_pmask, rd_ehi, rd_elo0, rd_elo1}, {e.w0, e.w1, e.w2, e.w3});
                    end else begin
                        check(res_idx_vld && (res_idx == e.w0), e.req, "probe",
                              {96'd0, res_idx}, {96'd0, e.w0});
                    end
                end
            end
        end
    end

    task automatic issue(input logic [1:0] code);
        @(negedge clk);
        op_code  = code;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] code, input logic [31:0] idx,
                            input logic [31:0] rnd, input logic [31:0] pm,
                            input logic [31:0] hi, input logic [31:0] lo0,
                            input logic [31:0] lo1);
        logic [31:0] slot;
        slot = ((code == 2'd3) || idx[31]) ? rnd : idx;
        if (slot < N) begin
            m_mask[slot] = pm;
            m_hi[slot]   = {hi[31:13], lo0[0] & lo1[0], hi[11:0]};
            m_lo0[slot]  = {lo0[31:1], 1'b0};
            m_lo1[slot]  = {lo1[31:1], 1'b0};
        end
        @(negedge clk);
        index_in = idx; rnd_in = rnd; pmask_in = pm;
        ehi_in = hi; elo0_in = lo0; elo1_in = lo1;
        issue(code);
    endtask

    task automatic do_read(input logic [31:0] idx, input string req);
        if (idx < N) begin
            exp_t e;
            logic g;
            g = m_hi[idx][12];
            e.is_read = 1'b1;
            e.w0 = m_mask[idx];
            e.w1 = {m_hi[idx][31:13], 1'b0, m_hi[idx][11:0]};
            e.w2 = m_lo0[idx] | {31'd0, g};
            e.w3 = m_lo1[idx] | {31'd0, g};
            e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        index_in = idx;
        issue(2'd1);
    endtask

    function automatic bit ent_match(input int i, input logic [31:0] va, input logic [7:0] id);
        logic [31:0] cm;
        cm = ~(m_mask[i] + 32'h1FFF);
        return ((va & 32'hFFFFE000 & cm) == (m_hi[i] & 32'hFFFFE000 & cm)) &&
               (m_hi[i][12] || (m_hi[i][7:0] == id));
    endfunction

    task automatic do_probe(input logic [31:0] hi, input string req);
        exp_t e;
        e.is_read = 1'b0;
        e.w0 = 32'h8000_0000;
        e.w1 = '0; e.w2 = '0; e.w3 = '0;
        e.req = req;
        for (int i = N - 1; i >= 0; i--) begin
            if (ent_match(i, hi, hi[7:0])) e.w0 = 32'(i);
        end
        exp_q.push_back(e);
        @(negedge clk);
        ehi_in = hi;
        issue(2'd0);
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic [7:0] id, input string req);
        int          hit_i;
        logic [31:0] ps, lo;
        logic [35:0] pa36;
        logic [PW-1:0] epa;
        logic        eh, ed, ev, eg;
        logic [IW-1:0] ei;
        hit_i = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (ent_match(i, va, id)) hit_i = i;
        end
        eh = 0; ed = 0; ev = 0; eg = 0; epa = '0; ei = '0;
        if (hit_i >= 0) begin
            ps   = (m_mask[hit_i] + 32'h2000) >> 1;
            lo   = ((va & ps) != 0) ? m_lo1[hit_i] : m_lo0[hit_i];
            pa36 = ({4'd0, lo} & 36'h03FFFFFC0) << 6;
            pa36 = pa36 + {4'd0, va & (ps - 1)};
            epa  = pa36[PW-1:0];
            eh = 1; ed = lo[2]; ev = lo[1]; eg = m_hi[hit_i][12];
            ei = IW'(hit_i);
        end
        @(negedge clk);
        lk_va = va;
        ehi_in = {24'd0, id};
        #2;
        check((lk_hit == eh) && (lk_index == ei) && (lk_pa == epa) && (lk_dirty == ed) &&
              (lk_valid == ev) && (lk_global == eg), req, "lookup",
              {88'd0, lk_hit, lk_index, lk_pa, lk_dirty, lk_valid, lk_global},
              {88'd0, eh, ei, epa, ed, ev, eg});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_mask[i] = '0; m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!rd_vld && !res_idx_vld, "R1", "strobes after reset",
              {126'd0, rd_vld, res_idx_vld}, 128'd0);
        do_read(32'd2, "R1");

        // R4 / R5 global fold and split
        do_write(2'd2, 32'd0, 32'd0, 32'h0, 32'h0040_0005, 32'h0000_4007, 32'h0000_4042);
        do_read(32'd0, "R4");
        do_write(2'd2, 32'd1, 32'd0, 32'h0, 32'h0080_0009, 32'h0000_8003, 32'h0000_8047);
        do_read(32'd1, "R5");
        do_write(2'd2, 32'd2, 32'd0, 32'h0001_E000, 32'h0100_0005,
                 32'h0000_C002, 32'h3FC0_C006);
        do_read(32'd2, "R4");

        // R2 probes
        do_probe(32'h0040_0005, "R2");
        do_probe(32'h0040_0006, "R2");
        do_probe(32'h0080_0033, "R2");
        do_probe(32'h0101_A005, "R2");

        // R8 / R9 / R10 lookups
        do_lookup(32'h0040_0ABC, 8'h05, "R8");
        do_lookup(32'h0040_1234, 8'h05, "R8");
        do_lookup(32'h0100_5123, 8'h05, "R9");
        do_lookup(32'h0101_0040, 8'h05, "R9");
        do_lookup(32'h0080_1FF0, 8'h33, "R10");
        do_lookup(32'h0700_0000, 8'h05, "R10");

        // R3 duplicate tag in a higher slot
        do_write(2'd2, 32'd3, 32'd0, 32'h0, 32'h0040_0005, 32'h0000_F006, 32'h0000_F106);
        do_probe(32'h0040_0005, "R3");
        do_lookup(32'h0040_1004, 8'h05, "R3");

        // R6 random slot writes
        do_write(2'd2, 32'h8000_0000, 32'd3, 32'h0, 32'h0200_0007, 32'h0001_0003, 32'h0001_0043);
        do_read(32'd3, "R6");
        do_write(2'd3, 32'd0, 32'd3, 32'h0000_6000, 32'h0300_0011, 32'h0002_0006, 32'h0002_0002);
        do_read(32'd3, "R6");
        do_lookup(32'h0300_4010, 8'h11, "R6");

        // R7 out-of-range operations have no effect
        do_read(32'd4, "R7");
        do_read(32'h8000_0001, "R7");
        do_write(2'd2, 32'd5, 32'd0, 32'h0, 32'h0500_0001, 32'h3, 32'h3);
        do_write(2'd3, 32'd0, 32'd4, 32'h0, 32'h0500_0001, 32'h3, 32'h3);
        do_write(2'd2, 32'h8000_0000, 32'd6, 32'h0, 32'h0500_0001, 32'h3, 32'h3);
        for (int i = 0; i < N; i++) do_read(32'(i), "R7");
        do_lookup(32'h0500_0000, 8'h01, "R7");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending results",
              128'(exp_q.size()), 128'd0);
        done = 1;
        finish_run();
    end

endmodule